// File: doc/BRIEF.md
# Address-Steered Codec Serial Register Port

This block is the synchronous serial port in front of a voice-band codec. Words of 16 bits are shifted in on a serial data input under the port clock. A single serial address line decides where each completed word is stored: either the D/A data register or one of four control registers. The same line also decides what the serial data output carries: bits of the latest A/D sample, or the converter's status flag.

The port has two modes. In the simple mode the address line is a one-bit, active-low control select. It is sampled on every clock edge, and the value taken with the last bit of a word fixes the destination. In multiprocessor mode the line carries 8-bit addresses in inverted form, least significant bit first. During a time slot assigned to transmission, the block drives its own transmit address onto the line. At all other times it listens, and it compares the received address with programmed receive addresses to pick the register that loads.

Time-slot generation, the converters and the meaning of the control bits lie outside this block.

Top module: `codec_serial_port`

## Requirements
- R1: In the simple mode, `addr_in` is sampled inverted on every rising `iock` edge. The value taken on the edge of the 16th bit of a word fixes the destination. A level of 1 (captured 0) writes the word to `dac_reg`. A level of 0 (captured 1) writes it to a control register.
- R2: A simple-mode control word selects control register `word[15:14]` (0 to 3). That register loads `{2'b00, word[13:0]}`.
- R3: While `shift_en` is high in the simple mode, `sdo` carries `adc_word` most significant bit first, one bit per edge. The value is taken at the first bit of the word. Once `addr_in` has been sampled low during the word, `sdo` carries `status_flag` for the rest of that word.
- R4: With `shift_en` low in the simple mode, `sdo` takes `status_flag` on the next edge when `addr_in` is low, and 0 when `addr_in` is high.
- R5: In multiprocessor mode with `tx_slot` high, `addr_oe` is 1 after each edge. The n-th edge of the slot (n counted from 0) puts the inverted `tx_addr[n]` on `addr_out`, for n from 0 to 7. Later edges of the slot drive 1. `addr_oe` returns to 0 on the first edge with `tx_slot` low.
- R6: In the simple mode, `addr_oe` is 0 after every edge, whatever the level of `tx_slot`.
- R7: In multiprocessor mode, the inverted `addr_in` levels of bits 0 to 7 of a word form the receive address, least significant bit first. They are taken only while `tx_slot` is low. A match with `dac_rx_addr` writes the full word to `dac_reg`. Otherwise, the lowest index i whose `ctl_rx_addr[8i+7:8i]` matches gets the full word. At most one register is written per word.
- R8: In multiprocessor mode, a word whose address matches no programmed receive address leaves every register unchanged.
- R9: `sdi` is shifted in most significant bit first on edges with `shift_en` high. The destination loads on the edge after the 16th bit. A word whose `shift_en` drops before the 16th bit is discarded, and the next word starts from bit 0.
- R10: With `rst` high on an edge, `dac_reg`, all control registers, `sdo`, `addr_out` and `addr_oe` become 0.
- R11: In multiprocessor mode, `sdo` carries the `adc_word` bits during a word, whatever the level of `addr_in`, and it is 0 while `shift_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iock | input | 1 | Serial port clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mp_mode | input | 1 | 0 selects the simple mode, 1 selects multiprocessor mode |
| shift_en | input | 1 | High for each edge that carries a word bit |
| sdi | input | 1 | Serial data input |
| addr_in | input | 1 | Address line level when not driven by the block |
| addr_out | output | 1 | Address line value while driving |
| addr_oe | output | 1 | Address line output enable |
| sdo | output | 1 | Serial data output |
| tx_slot | input | 1 | Transmit time slot marker (multiprocessor mode) |
| status_flag | input | 1 | Converter status flag |
| adc_word | input | 16 | A/D sample to shift out |
| tx_addr | input | 8 | Transmit address |
| dac_rx_addr | input | 8 | Receive address of the D/A data register |
| ctl_rx_addr | input | 32 | Receive addresses of control registers, 8 bits each, register 0 lowest |
| dac_reg | output | 16 | D/A data register |
| ctl_regs | output | 64 | Control registers, 16 bits each, register 0 lowest |

## Verification
The properties assume that `shift_en` stays high for the whole of a word, that `mp_mode` stays constant during a word, and that every input changes away from the rising `iock` edge. They also assume that nothing outside drives the address line while `addr_oe` is high. The bench drives all inputs on the falling edge and samples outputs on the falling edge as well. It keeps `mp_mode` fixed for the length of each word and never opens a transmit slot during a receive word. It drops `shift_en` early only in the test that checks that a partial word is discarded.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_NCTL   = 4;

  typedef enum logic {
    MODE_SIMPLE = 1'b0,
    MODE_MULTI  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/csp_rx_shift.sv
module csp_rx_shift
  import csp_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sdi,
  input  logic              addr_in,
  input  logic              tx_slot,
  output logic [WORD_W-1:0] word_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sel_ctl_q,
  output logic              wr_pulse,
  output logic              first_bit,
  output logic              ctl_now
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  bitcnt;
  logic [WORD_W-2:0] isr;
  logic [ADDR_W-1:0] asr;
  logic              ctl_seen;
  logic              last_bit;

  assign first_bit = (bitcnt == '0);
  assign last_bit  = shift_en && (bitcnt == CNT_W'(WORD_W - 1));
  // control marking is sticky inside a word, fresh at its first bit
  assign ctl_now   = ~addr_in | (ctl_seen & ~first_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt    <= '0;
      isr       <= '0;
      asr       <= '0;
      ctl_seen  <= 1'b0;
      word_q    <= '0;
      addr_q    <= '0;
      sel_ctl_q <= 1'b0;
      wr_pulse  <= 1'b0;
    end else begin
      wr_pulse <= last_bit;
      if (shift_en) begin
        isr      <= {isr[WORD_W-3:0], sdi};
        bitcnt   <= last_bit ? '0 : bitcnt + CNT_W'(1);
        ctl_seen <= ctl_now;
        if (bitcnt < CNT_W'(ADDR_W) && !tx_slot)
          asr <= {~addr_in, asr[ADDR_W-1:1]};
        if (last_bit) begin
          word_q    <= {isr, sdi};
          addr_q    <= asr;
          sel_ctl_q <= ~addr_in;
        end
      end else begin
        bitcnt   <= '0;
        ctl_seen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csp_regfile.sv
module csp_regfile
  import csp_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int NCTL   = DEF_NCTL
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mp_mode,
  input  logic                     wr_pulse,
  input  logic [WORD_W-1:0]        word_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic                     sel_ctl_q,
  input  logic [ADDR_W-1:0]        dac_rx_addr,
  input  logic [NCTL*ADDR_W-1:0]   ctl_rx_addr,
  output logic                     dac_we,
  output logic [NCTL-1:0]          ctl_we,
  output logic [WORD_W-1:0]        dac_reg,
  output logic [NCTL*WORD_W-1:0]   ctl_regs
);
  localparam int IDX_W = (NCTL > 1) ? $clog2(NCTL) : 1;

  logic [IDX_W-1:0]  simple_idx;
  logic [WORD_W-1:0] ctl_wdata;
  logic              found;
  port_mode_e        mode;

  assign mode       = port_mode_e'(mp_mode);
  assign simple_idx = word_q[WORD_W-1 -: IDX_W];
  assign ctl_wdata  = (mode == MODE_MULTI) ? word_q
                    : {{IDX_W{1'b0}}, word_q[WORD_W-IDX_W-1:0]};

  always_comb begin
    dac_we = 1'b0;
    ctl_we = '0;
    found  = 1'b0;
    if (wr_pulse) begin
      if (mode == MODE_SIMPLE) begin
        if (!sel_ctl_q) dac_we = 1'b1;
        else            ctl_we[simple_idx] = 1'b1;
      end else if (addr_q == dac_rx_addr) begin
        dac_we = 1'b1;
      end else begin
        for (int i = 0; i < NCTL; i++) begin
          if (!found && addr_q == ctl_rx_addr[i*ADDR_W +: ADDR_W]) begin
            ctl_we[i] = 1'b1;
            found     = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         dac_reg <= '0;
    else if (dac_we) dac_reg <= word_q;
  end

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    logic [WORD_W-1:0] ctl_r;
    always_ff @(posedge clk) begin
      if (rst)            ctl_r <= '0;
      else if (ctl_we[g]) ctl_r <= ctl_wdata;
    end
    assign ctl_regs[g*WORD_W +: WORD_W] = ctl_r;
  end
endmodule

// File: rtl/csp_tx.sv
module csp_tx
  import csp_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mp_mode,
  input  logic              shift_en,
  input  logic              first_bit,
  input  logic              ctl_now,
  input  logic              addr_in,
  input  logic              status_flag,
  input  logic [WORD_W-1:0] adc_word,
  input  logic              tx_slot,
  input  logic [ADDR_W-1:0] tx_addr,
  output logic              sdo,
  output logic              addr_out,
  output logic              addr_oe
);
  localparam int TCNT_W = $clog2(ADDR_W + 1);
  localparam int AIDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic [WORD_W-1:0] txsh;
  logic [TCNT_W-1:0] tcnt;
  logic              data_bit;
  logic              in_range;
  port_mode_e        mode;

  assign mode     = port_mode_e'(mp_mode);
  assign data_bit = first_bit ? adc_word[WORD_W-1] : txsh[WORD_W-1];
  assign in_range = (tcnt < TCNT_W'(ADDR_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      txsh     <= '0;
      sdo      <= 1'b0;
      tcnt     <= '0;
      addr_out <= 1'b0;
      addr_oe  <= 1'b0;
    end else begin
      if (shift_en) begin
        txsh <= first_bit ? (adc_word << 1) : (txsh << 1);
        sdo  <= (mode == MODE_SIMPLE && ctl_now) ? status_flag : data_bit;
      end else begin
        sdo  <= (mode == MODE_SIMPLE && !addr_in) ? status_flag : 1'b0;
      end

      if (mode == MODE_MULTI && tx_slot) begin
        addr_oe  <= 1'b1;
        addr_out <= in_range ? ~tx_addr[tcnt[AIDX_W-1:0]] : 1'b1;
        if (in_range) tcnt <= tcnt + TCNT_W'(1);
      end else begin
        addr_oe  <= 1'b0;
        addr_out <= 1'b0;
        tcnt     <= '0;
      end
    end
  end
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int NCTL   = DEF_NCTL
) (
  input  logic                   iock,
  input  logic                   rst,
  input  logic                   mp_mode,
  input  logic                   shift_en,
  input  logic                   sdi,
  input  logic                   addr_in,
  output logic                   addr_out,
  output logic                   addr_oe,
  output logic                   sdo,
  input  logic                   tx_slot,
  input  logic                   status_flag,
  input  logic [WORD_W-1:0]      adc_word,
  input  logic [ADDR_W-1:0]      tx_addr,
  input  logic [ADDR_W-1:0]      dac_rx_addr,
  input  logic [NCTL*ADDR_W-1:0] ctl_rx_addr,
  output logic [WORD_W-1:0]      dac_reg,
  output logic [NCTL*WORD_W-1:0] ctl_regs
);
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sel_ctl_q;
  logic              wr_pulse;
  logic              first_bit;
  logic              ctl_now;
  logic              dac_we;
  logic [NCTL-1:0]   ctl_we;

  csp_rx_shift #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(iock), .rst(rst), .shift_en(shift_en), .sdi(sdi),
    .addr_in(addr_in), .tx_slot(tx_slot), .word_q(word_q),
    .addr_q(addr_q), .sel_ctl_q(sel_ctl_q), .wr_pulse(wr_pulse),
    .first_bit(first_bit), .ctl_now(ctl_now)
  );

  csp_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NCTL(NCTL)) u_rf (
    .clk(iock), .rst(rst), .mp_mode(mp_mode), .wr_pulse(wr_pulse),
    .word_q(word_q), .addr_q(addr_q), .sel_ctl_q(sel_ctl_q),
    .dac_rx_addr(dac_rx_addr), .ctl_rx_addr(ctl_rx_addr),
    .dac_we(dac_we), .ctl_we(ctl_we), .dac_reg(dac_reg),
    .ctl_regs(ctl_regs)
  );

  csp_tx #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_tx (
    .clk(iock), .rst(rst), .mp_mode(mp_mode), .shift_en(shift_en),
    .first_bit(first_bit), .ctl_now(ctl_now), .addr_in(addr_in),
    .status_flag(status_flag), .adc_word(adc_word), .tx_slot(tx_slot),
    .tx_addr(tx_addr), .sdo(sdo), .addr_out(addr_out), .addr_oe(addr_oe)
  );
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int WORD_W = 16,
  parameter int NCTL   = 4
) (
  input logic                   iock,
  input logic                   rst,
  input logic                   mp_mode,
  input logic                   tx_slot,
  input logic                   shift_en,
  input logic                   addr_in,
  input logic                   status_flag,
  input logic                   addr_oe,
  input logic                   sdo,
  input logic                   wr_pulse,
  input logic                   dac_we,
  input logic [NCTL-1:0]        ctl_we,
  input logic [WORD_W-1:0]      dac_reg,
  input logic [NCTL*WORD_W-1:0] ctl_regs
);
  assert_simple_no_drive_R6: assert property (@(posedge iock) disable iff (rst)
    !mp_mode |=> !addr_oe);

  assert_tx_drive_R5: assert property (@(posedge iock) disable iff (rst)
    (mp_mode && tx_slot) |=> addr_oe);

  assert_idle_status_R4: assert property (@(posedge iock) disable iff (rst)
    (!mp_mode && !shift_en && !addr_in) |=> (sdo == $past(status_flag)));

  assert_one_dest_R7: assert property (@(posedge iock) disable iff (rst)
    $onehot0({dac_we, ctl_we}));

  assert_hold_no_word_R9: assert property (@(posedge iock) disable iff (rst)
    !wr_pulse |=> ($stable(dac_reg) && $stable(ctl_regs)));

  assert_write_after_bit_R9: assert property (@(posedge iock) disable iff (rst)
    wr_pulse |-> $past(shift_en));

  assert_reset_clear_R10: assert property (@(posedge iock)
    $past(rst) |-> (!addr_oe && !sdo && dac_reg == '0 && ctl_regs == '0));
endmodule

bind codec_serial_port csp_checker #(.WORD_W(WORD_W), .NCTL(NCTL)) u_chk (.*);

// File: tb/sim_codec_serial_port.sv
module sim_codec_serial_port;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  // vector: {mp, pin level, address[7:0], word[15:0]}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 16'hA5C3},
    {1'b0, 1'b0, 8'h00, 16'h8123},
    {1'b0, 1'b0, 8'h00, 16'hFFFF},
    {1'b1, 1'b0, 8'h21, 16'h1357},
    {1'b1, 1'b0, 8'h40, 16'hBEEF},
    {1'b1, 1'b0, 8'h99, 16'h2468},
    {1'b0, 1'b0, 8'h00, 16'h4ABC},
    {1'b1, 1'b0, 8'h43, 16'hC001}
  };

  logic        iock = 1'b0;
  logic        rst = 1'b1;
  logic        mp_mode = 1'b0, shift_en = 1'b0, sdi = 1'b0, addr_in = 1'b1;
  logic        tx_slot = 1'b0, status_flag = 1'b0;
  logic [15:0] adc_word = '0;
  logic [7:0]  tx_addr = 8'hB4, dac_rx_addr = 8'h21;
  logic [31:0] ctl_rx_addr = {8'h43, 8'h42, 8'h21, 8'h40};
  logic        addr_out, addr_oe, sdo;
  logic [15:0] dac_reg;
  logic [63:0] ctl_regs;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [15:0] m_dac;
  logic [15:0] m_ctl [4];

  always #(CLK_P/2) iock = ~iock;

  codec_serial_port u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_do(bit mp, logic [15:0] pinv, logic [15:0] adcw, bit st);
    logic [15:0] r;
    bit seen = 0;
    for (int k = 0; k < 16; k++) begin
      if (!mp && !pinv[k]) seen = 1;
      r[15-k] = (!mp && seen) ? st : adcw[15-k];
    end
    return r;
  endfunction

  task automatic model(bit mp, logic [15:0] pinv, logic [7:0] a, logic [15:0] w);
    bit hit = 0;
    if (!mp) begin
      if (pinv[15]) m_dac = w;
      else m_ctl[w[15:14]] = {2'b00, w[13:0]};
    end else if (a == dac_rx_addr) m_dac = w;
    else
      for (int i = 0; i < 4; i++)
        if (!hit && a == ctl_rx_addr[i*8 +: 8]) begin m_ctl[i] = w; hit = 1; end
  endtask

  task automatic send_word(bit mp, logic [15:0] pinv, logic [7:0] a, logic [15:0] w,
                           logic [15:0] adcw, output logic [15:0] dos);
    mp_mode = mp;
    adc_word = adcw;
    for (int k = 0; k < 16; k++) begin
      @(negedge iock);
      if (k > 0) dos[16-k] = sdo;
      shift_en = 1'b1;
      sdi = w[15-k];
      addr_in = mp ? ((k < 8) ? ~a[k] : 1'b1) : pinv[k];
    end
    @(negedge iock);
    dos[0] = sdo;
    shift_en = 1'b0;
    addr_in = 1'b1;
    @(negedge iock);
  endtask

  task automatic check_regs(string tag);
    chk(dac_reg === m_dac, {tag, " dac_reg"}, dac_reg, m_dac);
    for (int i = 0; i < 4; i++)
      chk(ctl_regs[i*16 +: 16] === m_ctl[i], {tag, " ctl_reg"}, ctl_regs[i*16 +: 16], m_ctl[i]);
  endtask

  task automatic run_word(bit mp, logic [15:0] pinv, logic [7:0] a, logic [15:0] w, string tag);
    logic [15:0] dos, adcw, e;
    adcw = w ^ 16'h5A5A;
    status_flag = 1'b1;
    send_word(mp, pinv, a, w, adcw, dos);
    model(mp, pinv, a, w);
    e = exp_do(mp, pinv, adcw, 1'b1);
    chk(dos === e, {tag, " sdo stream R3 R11"}, dos, e);
    check_regs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge iock);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] dos;
    m_dac = '0;
    for (int i = 0; i < 4; i++) m_ctl[i] = '0;
    repeat (3) @(negedge iock);
    rst = 1'b0;
    // R10: reset state
    chk(dac_reg === 16'h0 && ctl_regs === 64'h0, "R10 regs after reset", dac_reg, 0);
    chk(addr_oe === 1'b0 && sdo === 1'b0, "R10 oe/sdo after reset", {addr_oe, sdo}, 0);

    // table walk: R1 R2 R7 R8 R9 R11
    for (int v = 0; v < NV; v++)
      run_word(VEC[v][25], {16{VEC[v][24]}}, VEC[v][23:16], VEC[v][15:0], "R1 R2 R7 R8 vector");

    // R8: unmatched address leaves registers as they were
    run_word(1'b1, 16'hFFFF, 8'h7F, 16'h0F0F, "R8 no match");

    // R3/R1: pin high for bits 0-3 then low -> control word, status sticky after switch
    run_word(1'b0, 16'h000F, 8'h00, 16'h0011, "R3 switch to control");
    // R1/R3: low first then high -> last sample routes to dac, status stays sticky
    run_word(1'b0, 16'hFF00, 8'h00, 16'h7E7E, "R1 last sample decides");

    // R9: partial word discarded, next word starts from bit 0
    mp_mode = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge iock);
      shift_en = 1'b1; sdi = 1'b1; addr_in = 1'b1;
    end
    @(negedge iock); shift_en = 1'b0;
    repeat (2) @(negedge iock);
    check_regs("R9 partial word");
    run_word(1'b0, 16'hFFFF, 8'h00, 16'h3C3C, "R9 word after abort");

    // R4: idle output in simple mode
    mp_mode = 1'b0; status_flag = 1'b1; addr_in = 1'b0;
    @(negedge iock);
    chk(sdo === 1'b1, "R4 idle pin low status 1", sdo, 1);
    status_flag = 1'b0;
    @(negedge iock);
    chk(sdo === 1'b0, "R4 idle pin low status 0", sdo, 0);
    status_flag = 1'b1; addr_in = 1'b1;
    @(negedge iock);
    chk(sdo === 1'b0, "R4 idle pin high", sdo, 0);

    // R11: idle output in multiprocessor mode is 0
    mp_mode = 1'b1; addr_in = 1'b0;
    @(negedge iock);
    chk(sdo === 1'b0, "R11 mp idle sdo", sdo, 0);
    addr_in = 1'b1;

    // R5: transmit address, inverted, LSB first, then 1
    tx_slot = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge iock);
      chk(addr_oe === 1'b1, "R5 oe during slot", addr_oe, 1);
      chk(addr_out === ((j < 8) ? ~tx_addr[j] : 1'b1), "R5 addr bit", addr_out,
          (j < 8) ? ~tx_addr[j] : 1'b1);
    end
    tx_slot = 1'b0;
    @(negedge iock);
    chk(addr_oe === 1'b0, "R5 oe after slot", addr_oe, 0);

    // R6: simple mode never drives the address line
    mp_mode = 1'b0; tx_slot = 1'b1;
    repeat (3) begin
      @(negedge iock);
      chk(addr_oe === 1'b0, "R6 simple mode oe", addr_oe, 0);
    end
    tx_slot = 1'b0;

    // R10: reset after activity
    mp_mode = 1'b1; tx_slot = 1'b1;
    @(negedge iock);
    rst = 1'b1;
    @(negedge iock);
    chk(dac_reg === 16'h0 && ctl_regs === 64'h0, "R10 regs after late reset", dac_reg, 0);
    chk(addr_oe === 1'b0 && addr_out === 1'b0, "R10 oe after late reset", addr_oe, 0);
    tx_slot = 1'b0; rst = 1'b0;
    @(negedge iock);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule